// File: doc/BRIEF.md
# Dual-Precision Dot-Product Compute Lane

This block is one compute lane of a neural inference datapath. On every accepted beat it takes sixteen signed 8-bit activations and a 128-bit weight bundle. A per-beat precision select decides how the bundle is read. In full precision it holds sixteen signed 8-bit weights and the lane returns one neuron sum. In half precision the same bits hold thirty-two signed 4-bit weights, and the lane returns two independent neuron sums over the same activations. This doubles neuron throughput when coarse weights are good enough.

Each of the sixteen multipliers is built from two 8x4 partial products. In full precision the two partials are shifted and summed into one 8x8 product. In half precision they are kept apart as two results. The products feed a binary tree of split adders. In full precision each adder lets the carry pass from its lower half into its upper half. In half precision it blocks that carry, so the tree works as two independent trees. There are two register stages, so a result appears a fixed two cycles after its input beat.

Top module: `dual_prec_dot_lane`

## Requirements
- R1: With half_i low on a beat, sum_a_o equals the signed sum over lanes k=0..15 of act[k]*wgt[k]. Here act[k] is act_i[8k+7:8k] and wgt[k] is wgt_i[8k+7:8k], both two's complement. The result is a 32-bit two's complement value.
- R2: With half_i high on a beat, sum_a_o equals the sum of act[k] times the sign-extended low nibble wgt_i[8k+3:8k], sign-extended to 32 bits.
- R3: With half_i high on a beat, sum_b_o equals the sum of act[k] times the sign-extended high nibble wgt_i[8k+7:8k+4], as a 16-bit two's complement value.
- R4: For a full-precision result, sum_b_o is zero.
- R5: valid_o is high in exactly the cycles that come two clock edges after a beat with valid_i high. half_o carries the half_i value of that beat.
- R6: Precision is taken per beat. Back-to-back beats in different modes each produce their own correct result, with no influence from their neighbours.
- R7: No result wraps, even when every operand sits at its extreme. Full precision with all -128 by -128 gives 262144. Half precision with all -128 by -8 gives 16384 in each sum.
- R8: While valid_o is low, sum_a_o, sum_b_o and half_o hold the values of the last result. Beats with valid_i low change nothing.
- R9: While rst_ni is low, valid_o, half_o, sum_a_o and sum_b_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input beat valid |
| half_i | input | 1 | 1 = half precision (two 4-bit weights per lane), 0 = full precision |
| act_i | input | 128 | Sixteen signed 8-bit activations, lane k at bits 8k+7:8k |
| wgt_i | input | 128 | Weight bundle, lane k at bits 8k+7:8k |
| valid_o | output | 1 | Result valid |
| half_o | output | 1 | Precision of the presented result |
| sum_a_o | output | 32 | Full-precision sum, or neuron A sum sign-extended |
| sum_b_o | output | 16 | Neuron B sum in half precision, zero in full precision |

## Verification
A carry that leaks across the split boundary shows up in half precision as a neuron B sum that is off by one whenever neuron A's low half overflows. A carry that is blocked in full precision shows up as a wrong upper half of sum_a_o. Either error reaches the ports two cycles after the beat that triggers it. A precision tag that does not travel with its data corrupts the first result after a mode change. For this reason the random stream mixes modes beat by beat, with idle gaps between beats, and extreme operands are driven directly to expose missing sign extension or an adder that is too narrow.

// File: rtl/dpl_pkg.sv
package dpl_pkg;
  typedef enum logic {
    PREC_FULL = 1'b0,
    PREC_HALF = 1'b1
  } prec_e;
endpackage

// File: rtl/dpl_mult.sv
module dpl_mult #(
  parameter int ACT_W  = 8,
  parameter int WGT_W  = 8,
  parameter int SUM_HW = 16
) (
  input  logic [ACT_W-1:0]    act_i,
  input  logic [WGT_W-1:0]    wgt_i,
  input  logic                half_i,
  output logic [2*SUM_HW-1:0] word_o
);
  localparam int HW   = WGT_W / 2;
  localparam int PL_W = ACT_W + HW + 1;
  localparam int PH_W = ACT_W + HW;
  localparam int FP_W = ACT_W + WGT_W;
  localparam int LW   = 2 * SUM_HW;

  logic signed [HW:0]      lo_x;
  logic signed [PL_W-1:0]  p_lo;
  logic signed [PH_W-1:0]  p_hi;
  logic signed [FP_W-1:0]  p_full;

  always_comb begin
    // low nibble: signed weight in half mode, unsigned partial in full mode
    lo_x   = {half_i & wgt_i[HW-1], wgt_i[HW-1:0]};
    p_lo   = PL_W'($signed(act_i)) * PL_W'(lo_x);
    p_hi   = PH_W'($signed(act_i)) * PH_W'($signed(wgt_i[WGT_W-1:HW]));
    p_full = (FP_W'(p_hi) <<< HW) + FP_W'(p_lo);
    if (half_i) word_o = {SUM_HW'(p_hi), SUM_HW'(p_lo)};
    else        word_o = LW'(p_full);
  end
endmodule

// File: rtl/dpl_split_add.sv
module dpl_split_add #(
  parameter int H = 16
) (
  input  logic [2*H-1:0] a_i,
  input  logic [2*H-1:0] b_i,
  input  logic           full_i,
  output logic [2*H-1:0] sum_o
);
  logic [H:0]   lo;
  logic [H-1:0] hi;
  logic         c;

  always_comb begin
    lo    = {1'b0, a_i[H-1:0]} + {1'b0, b_i[H-1:0]};
    c     = full_i & lo[H];
    hi    = a_i[2*H-1:H] + b_i[2*H-1:H] + H'(c);
    sum_o = {hi, lo[H-1:0]};
  end
endmodule

// File: rtl/dpl_adder_tree.sv
module dpl_adder_tree #(
  parameter int N_LANES = 16,
  parameter int SUM_HW  = 16
) (
  input  logic [2*SUM_HW-1:0] words_i [N_LANES],
  input  logic                full_i,
  output logic [2*SUM_HW-1:0] sum_o
);
  localparam int LW    = 2 * SUM_HW;
  localparam int NODES = 2 * N_LANES - 1;

  // heap layout: node 0 is root, leaves at N_LANES-1 .. NODES-1
  logic [LW-1:0] node [NODES];

  for (genvar i = 0; i < N_LANES; i++) begin : g_leaf
    assign node[N_LANES-1+i] = words_i[i];
  end

  for (genvar i = 0; i < N_LANES - 1; i++) begin : g_add
    dpl_split_add #(.H(SUM_HW)) u_add (
      .a_i   (node[2*i+1]),
      .b_i   (node[2*i+2]),
      .full_i(full_i),
      .sum_o (node[i])
    );
  end

  assign sum_o = node[0];
endmodule

// File: rtl/dual_prec_dot_lane.sv
module dual_prec_dot_lane
  import dpl_pkg::*;
#(
  parameter int N_LANES = 16,
  parameter int ACT_W   = 8,
  parameter int WGT_W   = 8,
  parameter int SUM_HW  = ACT_W + WGT_W / 2 + $clog2(N_LANES),
  parameter int LW      = 2 * SUM_HW
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic                     half_i,
  input  logic [N_LANES*ACT_W-1:0] act_i,
  input  logic [N_LANES*WGT_W-1:0] wgt_i,
  output logic                     valid_o,
  output logic                     half_o,
  output logic [LW-1:0]            sum_a_o,
  output logic [SUM_HW-1:0]        sum_b_o
);
  logic [LW-1:0] prod_w [N_LANES];
  logic [LW-1:0] s1_word [N_LANES];
  logic          s1_valid;
  prec_e         s1_prec;
  logic [LW-1:0] root;
  logic [LW-1:0] sum_a_d;
  logic [SUM_HW-1:0] sum_b_d;

  for (genvar k = 0; k < N_LANES; k++) begin : g_lane
    dpl_mult #(.ACT_W(ACT_W), .WGT_W(WGT_W), .SUM_HW(SUM_HW)) u_mult (
      .act_i (act_i[k*ACT_W +: ACT_W]),
      .wgt_i (wgt_i[k*WGT_W +: WGT_W]),
      .half_i(half_i),
      .word_o(prod_w[k])
    );
  end

  // stage 1: products with their precision tag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_prec  <= PREC_FULL;
      for (int k = 0; k < N_LANES; k++) s1_word[k] <= '0;
    end else begin
      s1_valid <= valid_i;
      if (valid_i) begin
        s1_prec <= prec_e'(half_i);
        for (int k = 0; k < N_LANES; k++) s1_word[k] <= prod_w[k];
      end
    end
  end

  dpl_adder_tree #(.N_LANES(N_LANES), .SUM_HW(SUM_HW)) u_tree (
    .words_i(s1_word),
    .full_i (s1_prec == PREC_FULL),
    .sum_o  (root)
  );

  always_comb begin
    if (s1_prec == PREC_HALF) begin
      sum_a_d = LW'($signed(root[SUM_HW-1:0]));
      sum_b_d = root[LW-1:SUM_HW];
    end else begin
      sum_a_d = root;
      sum_b_d = '0;
    end
  end

  // stage 2: result registers, held between results
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      half_o  <= 1'b0;
      sum_a_o <= '0;
      sum_b_o <= '0;
    end else begin
      valid_o <= s1_valid;
      if (s1_valid) begin
        half_o  <= (s1_prec == PREC_HALF);
        sum_a_o <= sum_a_d;
        sum_b_o <= sum_b_d;
      end
    end
  end
endmodule

// File: rtl/dpl_checker.sv
module dpl_checker #(
  parameter int SUM_HW = 16,
  parameter int LW     = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              half_i,
  input logic              valid_o,
  input logic              half_o,
  input logic [LW-1:0]     sum_a_o,
  input logic [SUM_HW-1:0] sum_b_o
);
  logic [1:0] cyc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  p_latency_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 2'd2) |-> (valid_o == $past(valid_i, 2)));

  p_mode_tag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 2'd2 && valid_o) |-> (half_o == $past(half_i, 2)));

  p_full_b_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !half_o) |-> (sum_b_o == '0));

  p_half_sext_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && half_o) |->
      ($countones(sum_a_o[LW-1:SUM_HW-1]) == 0 ||
       $countones(sum_a_o[LW-1:SUM_HW-1]) == LW - SUM_HW + 1));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 2'd1 && !valid_o) |->
      ($stable(sum_a_o) && $stable(sum_b_o) && $stable(half_o)));
endmodule

bind dual_prec_dot_lane dpl_checker #(.SUM_HW(SUM_HW), .LW(LW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .half_i (half_i),
  .valid_o(valid_o),
  .half_o (half_o),
  .sum_a_o(sum_a_o),
  .sum_b_o(sum_b_o)
);

// File: tb/dual_prec_dot_lane_test.sv
module dual_prec_dot_lane_test;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic         half_i = 1'b0;
  logic [127:0] act_i = '0;
  logic [127:0] wgt_i = '0;
  logic         valid_o, half_o;
  logic [31:0]  sum_a_o;
  logic [15:0]  sum_b_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // pipeline model: expectations of beats driven 1 and 2 negedges ago
  bit h1_v = 0, h2_v = 0, h1_h = 0, h2_h = 0, h1_sw = 0, h2_sw = 0;
  int h1_a = 0, h2_a = 0, h1_b = 0, h2_b = 0;
  int held_a = 0, held_b = 0;
  bit held_h = 0, last_h = 0, any_beat = 0;

  always #2.5 clk_i = ~clk_i;

  dual_prec_dot_lane uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .half_i(half_i),
    .act_i(act_i), .wgt_i(wgt_i), .valid_o(valid_o), .half_o(half_o),
    .sum_a_o(sum_a_o), .sum_b_o(sum_b_o)
  );

  function automatic int f_full(logic [127:0] a, logic [127:0] w);
    int s = 0;
    for (int k = 0; k < 16; k++)
      s += int'($signed(a[k*8 +: 8])) * int'($signed(w[k*8 +: 8]));
    return s;
  endfunction

  function automatic int f_half(logic [127:0] a, logic [127:0] w, bit hi);
    int s = 0;
    logic [3:0] nib;
    for (int k = 0; k < 16; k++) begin
      nib = hi ? w[k*8+4 +: 4] : w[k*8 +: 4];
      s += int'($signed(a[k*8 +: 8])) * int'($signed(nib));
    end
    return s;
  endfunction

  task automatic chk(string tag, int got, int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic check_outputs();
    chk("R5 valid_o", int'(valid_o), int'(h2_v));
    if (h2_v) begin
      held_a = h2_a; held_b = h2_b; held_h = h2_h;
      chk("R5 half_o", int'(half_o), int'(h2_h));
      if (h2_sw) chk("R6 sum_a after mode change", int'($signed(sum_a_o)), h2_a);
      else chk(h2_h ? "R2 sum_a half" : "R1 sum_a full", int'($signed(sum_a_o)), h2_a);
      chk(h2_h ? "R3 sum_b half" : "R4 sum_b full", int'($signed(sum_b_o)), h2_b);
    end else begin
      chk("R8 hold sum_a", int'($signed(sum_a_o)), held_a);
      chk("R8 hold sum_b", int'($signed(sum_b_o)), held_b);
      chk("R8 hold half_o", int'(half_o), int'(held_h));
    end
  endtask

  task automatic step(bit v, bit h, logic [127:0] a, logic [127:0] w);
    @(negedge clk_i);
    check_outputs();
    h2_v = h1_v; h2_h = h1_h; h2_a = h1_a; h2_b = h1_b; h2_sw = h1_sw;
    h1_v = v; h1_h = h; h1_sw = v && any_beat && (h != last_h);
    h1_a = h ? f_half(a, w, 1'b0) : f_full(a, w);
    h1_b = h ? f_half(a, w, 1'b1) : 0;
    if (v) begin last_h = h; any_beat = 1; end
    valid_i = v; half_i = h; act_i = a; wgt_i = w;
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    // R9 reset state, with live inputs ignored
    valid_i = 1'b1; half_i = 1'b1; act_i = '1; wgt_i = '1;
    @(negedge clk_i);
    chk("R9 valid_o", int'(valid_o), 0);
    chk("R9 half_o", int'(half_o), 0);
    chk("R9 sum_a", int'(sum_a_o), 0);
    chk("R9 sum_b", int'(sum_b_o), 0);
    valid_i = 1'b0; half_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R7 extremes
    step(1, 0, {16{8'h80}}, {16{8'h80}});
    step(1, 1, {16{8'h80}}, {16{8'h88}});
    step(1, 0, {16{8'h80}}, {16{8'h7f}});
    step(1, 1, {16{8'h7f}}, {16{8'h77}});
    step(1, 1, {16{8'h80}}, {16{8'h78}});
    step(0, 0, '0, '0);
    step(0, 1, rnd128(), rnd128());
    // R7 directed value checks land in the stream above; verify one explicitly
    if (f_full({16{8'h80}}, {16{8'h80}}) != 262144) chk("R7 model", 0, 1);
    // R6 alternating back-to-back
    for (int i = 0; i < 40; i++) step(1, i[0], rnd128(), rnd128());
    // random mix
    for (int i = 0; i < 3000; i++)
      step(($urandom % 10) < 7, $urandom % 2, rnd128(), rnd128());
    step(0, 0, '0, '0);
    step(0, 0, '0, '0);
    step(0, 0, '0, '0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    done = 1;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule